// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block keeps the coherence state of each line of a small private, direct-mapped cache that shares a snooping bus with other caching agents. For every line it holds an address tag and one of four states: Modified, Exclusive, Shared or Invalid. It serves processor reads and writes against that state. It raises bus requests only when the protocol needs them: a fill read, a read that claims ownership, an ownership claim without data, or a writeback of a dirty victim. It also answers snooped requests from other agents.

Processor requests are combinational lookups. A hit completes in the cycle the request is presented. A request that needs the bus completes, or makes progress, in the cycle the external arbiter grants it. A snooped request is looked up in the cycle it appears. The line's state changes at the next clock edge, and the registered snoop response is driven during the following cycle. That response has two signals. One reports that this cache holds a copy. The other reports that this cache supplies the data in place of memory, which suppresses the memory data response. A snoop takes the tag-and-state array for its cycle. A processor request presented in that cycle is not served and retries on the next cycle against the updated state.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, so the first processor access to any address is a miss that requests the bus.
- R2: A read miss requests a fill read (bus command 0, address = the request address). In the grant cycle the access completes. The line is filled Shared when the bus shared input is 1, and Exclusive when it is 0.
- R3: A write miss requests a read-for-ownership (bus command 1, address = the request address). In the grant cycle the access completes and the line becomes Modified.
- R4: A write that hits an Exclusive line completes in the cycle it is presented, with no bus request, and the line becomes Modified.
- R5: A write that hits a Shared line requests an ownership claim without data (bus command 2). In the grant cycle the access completes and the line becomes Modified.
- R6: A snooped read (snoop command 0) that hits a valid line drives the shared response in the next cycle and leaves the line Shared. If the line was Modified, the intervention response is also driven in that cycle.
- R7: A snooped write intent (snoop command 1 or 2) that hits a valid line invalidates it. The intervention response is driven in the next cycle only if the line was Modified. The shared response stays 0.
- R8: A read hit on any valid line, or a write hit on a Modified line, completes in the cycle it is presented, with no bus request.
- R9: While the snoop valid input is high, no bus request is raised and no processor access completes. The held processor request is served on a later cycle against the state the snoop left.
- R10: A miss whose direct-mapped victim is Modified with another tag first requests a writeback (bus command 3, address = victim tag concatenated with index). The grant makes the victim Invalid without completing the access. The fill request follows on the next cycle.
- R11: A snoop that misses, or a snooped writeback (command 3), drives no response and changes no line state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor access present |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | AW | Line address of the access |
| cpu_done | output | 1 | Access completes this cycle |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 ownership claim, 3 writeback |
| bus_req_addr | output | AW | Line address of the bus transaction |
| bus_gnt | input | 1 | Arbiter grant; the transaction happens this cycle |
| bus_shared_in | input | 1 | Another cache holds the line (valid with the grant) |
| snp_valid | input | 1 | Snooped request from another agent |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_req_cmd |
| snp_addr | input | AW | Snooped line address |
| snp_shared | output | 1 | Snoop response: copy held (cycle after snoop) |
| snp_intervene | output | 1 | Snoop response: this cache supplies the data and memory stays silent |

## Verification
Processor outcomes (completion, bus request, command and address) are due in the same cycle as the stimulus. The bench applies inputs on the falling edge and samples one time step later, before the next rising edge. Line-state changes land at the following rising edge. They show up only through later accesses and snoops, so the directed checks probe state with a follow-up operation in a later cycle. Snoop responses are due exactly one cycle after the snoop. A behavioural model in the bench carries the expected response across that edge and compares every output on every cycle, through both the directed phase and a long random phase.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    CMD_READ = 2'd0,
    CMD_RFO  = 2'd1,
    CMD_CLM  = 2'd2,
    CMD_WB   = 2'd3
  } bus_cmd_t;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int TW     = 5,
  localparam int IW    = $clog2(NLINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] cpu_idx,
  output logic [TW-1:0] cpu_tag,
  output line_st_t      cpu_st,
  input  logic [IW-1:0] snp_idx,
  output logic [TW-1:0] snp_tag,
  output line_st_t      snp_st,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [TW-1:0] wr_tag,
  input  line_st_t      wr_st
);
  line_st_t      st_all  [NLINES];
  logic [TW-1:0] tag_all [NLINES];

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    line_st_t      st_r;
    logic [TW-1:0] tag_r;
    logic          line_we;

    assign line_we = wr_en && (wr_idx == IW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_r  <= ST_I;
        tag_r <= '0;
      end else if (line_we) begin
        st_r  <= wr_st;
        tag_r <= wr_tag;
      end
    end

    assign st_all[i]  = st_r;
    assign tag_all[i] = tag_r;
  end

  assign cpu_tag = tag_all[cpu_idx];
  assign cpu_st  = st_all[cpu_idx];
  assign snp_tag = tag_all[snp_idx];
  assign snp_st  = st_all[snp_idx];
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          snp_valid,
  input  bus_cmd_t      snp_cmd,
  input  logic [TW-1:0] snp_tag,
  input  logic [TW-1:0] line_tag,
  input  line_st_t      line_st,
  output logic          upd_en,
  output line_st_t      upd_st,
  output logic          resp_shared,
  output logic          resp_intervene
);
  logic hit;
  logic shared_d, intervene_d;
  logic shared_q, intervene_q;

  assign hit = snp_valid && (line_st != ST_I) && (line_tag == snp_tag);

  always_comb begin
    upd_en      = 1'b0;
    upd_st      = line_st;
    shared_d    = 1'b0;
    intervene_d = 1'b0;
    if (hit) begin
      unique case (snp_cmd)
        CMD_READ: begin
          upd_en      = 1'b1;
          upd_st      = ST_S;
          shared_d    = 1'b1;
          intervene_d = (line_st == ST_M);
        end
        CMD_RFO, CMD_CLM: begin
          upd_en      = 1'b1;
          upd_st      = ST_I;
          intervene_d = (line_st == ST_M);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shared_q    <= 1'b0;
      intervene_q <= 1'b0;
    end else begin
      shared_q    <= shared_d;
      intervene_q <= intervene_d;
    end
  end

  assign resp_shared    = shared_q;
  assign resp_intervene = intervene_q;

  // R6 / R7: a response only ever follows a snoop by one cycle
  a_r6_resp_follows_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_shared || resp_intervene) |-> $past(snp_valid));

  // R7: write-intent snoops never report a shared copy
  a_r7_no_shared_on_claim: assert property (@(posedge clk) disable iff (!rst_n)
    resp_shared |-> $past(snp_cmd == CMD_READ));
endmodule

// File: rtl/mesi_cpu_unit.sv
module mesi_cpu_unit
  import mesi_pkg::*;
#(
  parameter int IW = 3,
  parameter int TW = 5,
  localparam int AW = IW + TW
) (
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [IW-1:0] req_idx,
  input  logic [TW-1:0] req_tag,
  input  logic          snp_busy,
  input  logic [TW-1:0] line_tag,
  input  line_st_t      line_st,
  input  logic          gnt,
  input  logic          shared_in,
  output logic          bus_valid,
  output bus_cmd_t      bus_cmd,
  output logic [AW-1:0] bus_addr,
  output logic          done,
  output logic          upd_en,
  output logic [TW-1:0] upd_tag,
  output line_st_t      upd_st
);
  logic active, hit, dirty_victim;

  assign active       = req_valid && !snp_busy;
  assign hit          = (line_st != ST_I) && (line_tag == req_tag);
  assign dirty_victim = !hit && (line_st == ST_M);

  always_comb begin
    bus_valid = 1'b0;
    bus_cmd   = CMD_READ;
    bus_addr  = {req_tag, req_idx};
    done      = 1'b0;
    upd_en    = 1'b0;
    upd_tag   = req_tag;
    upd_st    = line_st;
    if (active) begin
      if (dirty_victim) begin
        bus_valid = 1'b1;
        bus_cmd   = CMD_WB;
        bus_addr  = {line_tag, req_idx};
        upd_en    = gnt;
        upd_tag   = line_tag;
        upd_st    = ST_I;
      end else if (!req_write) begin
        if (hit) begin
          done = 1'b1;
        end else begin
          bus_valid = 1'b1;
          bus_cmd   = CMD_READ;
          done      = gnt;
          upd_en    = gnt;
          upd_st    = shared_in ? ST_S : ST_E;
        end
      end else begin
        if (hit && (line_st == ST_M || line_st == ST_E)) begin
          done   = 1'b1;
          upd_en = (line_st == ST_E);
          upd_st = ST_M;
        end else begin
          bus_valid = 1'b1;
          bus_cmd   = hit ? CMD_CLM : CMD_RFO;
          done      = gnt;
          upd_en    = gnt;
          upd_st    = ST_M;
        end
      end
    end
  end
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int AW     = 8,
  parameter int NLINES = 8,
  localparam int IW    = $clog2(NLINES),
  localparam int TW    = AW - IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req_valid,
  input  logic          cpu_req_write,
  input  logic [AW-1:0] cpu_req_addr,
  output logic          cpu_done,
  output logic          bus_req_valid,
  output logic [1:0]    bus_req_cmd,
  output logic [AW-1:0] bus_req_addr,
  input  logic          bus_gnt,
  input  logic          bus_shared_in,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_shared,
  output logic          snp_intervene
);
  logic [IW-1:0] c_idx, s_idx, w_idx;
  logic [TW-1:0] c_tag, s_tag, c_line_tag, s_line_tag, w_tag, cu_tag;
  line_st_t      c_line_st, s_line_st, su_st, cu_st, w_st;
  logic          su_en, cu_en, w_en;
  bus_cmd_t      cmd_o;

  assign c_idx = cpu_req_addr[IW-1:0];
  assign c_tag = cpu_req_addr[AW-1:IW];
  assign s_idx = snp_addr[IW-1:0];
  assign s_tag = snp_addr[AW-1:IW];

  mesi_line_store #(.NLINES(NLINES), .TW(TW)) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cpu_idx (c_idx),
    .cpu_tag (c_line_tag),
    .cpu_st  (c_line_st),
    .snp_idx (s_idx),
    .snp_tag (s_line_tag),
    .snp_st  (s_line_st),
    .wr_en   (w_en),
    .wr_idx  (w_idx),
    .wr_tag  (w_tag),
    .wr_st   (w_st)
  );

  mesi_snoop_unit #(.TW(TW)) snoop_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .snp_valid      (snp_valid),
    .snp_cmd        (bus_cmd_t'(snp_cmd)),
    .snp_tag        (s_tag),
    .line_tag       (s_line_tag),
    .line_st        (s_line_st),
    .upd_en         (su_en),
    .upd_st         (su_st),
    .resp_shared    (snp_shared),
    .resp_intervene (snp_intervene)
  );

  mesi_cpu_unit #(.IW(IW), .TW(TW)) cpu_i (
    .req_valid (cpu_req_valid),
    .req_write (cpu_req_write),
    .req_idx   (c_idx),
    .req_tag   (c_tag),
    .snp_busy  (snp_valid),
    .line_tag  (c_line_tag),
    .line_st   (c_line_st),
    .gnt       (bus_gnt),
    .shared_in (bus_shared_in),
    .bus_valid (bus_req_valid),
    .bus_cmd   (cmd_o),
    .bus_addr  (bus_req_addr),
    .done      (cpu_done),
    .upd_en    (cu_en),
    .upd_tag   (cu_tag),
    .upd_st    (cu_st)
  );

  assign bus_req_cmd = cmd_o;

  // snoop owns the single write port whenever it updates a line
  always_comb begin
    if (su_en) begin
      w_en  = 1'b1;
      w_idx = s_idx;
      w_tag = s_line_tag;
      w_st  = su_st;
    end else begin
      w_en  = cu_en;
      w_idx = c_idx;
      w_tag = cu_tag;
      w_st  = cu_st;
    end
  end

  // R9: the processor side stays off the bus while a snoop is served
  a_r9_snoop_priority: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> (!bus_req_valid && !cpu_done));

  // R9: the two update sources never write in the same cycle
  a_r9_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
    !(su_en && cu_en));

  // R8: completion only for a presented request
  a_r8_done_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> cpu_req_valid);

  // R10: a writeback grant never completes the access
  a_r10_wb_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_req_cmd == 2'd3) |-> !cpu_done);
endmodule

// File: tb/mesi_snoop_ctrl_tb.sv
module mesi_snoop_ctrl_tb_top;
  logic       clk, rst_n;
  logic       cpu_req_valid, cpu_req_write;
  logic [7:0] cpu_req_addr;
  logic       cpu_done;
  logic       bus_req_valid;
  logic [1:0] bus_req_cmd;
  logic [7:0] bus_req_addr;
  logic       bus_gnt, bus_shared_in;
  logic       snp_valid;
  logic [1:0] snp_cmd;
  logic [7:0] snp_addr;
  logic       snp_shared, snp_intervene;

  mesi_snoop_ctrl #(.AW(8), .NLINES(8)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .cpu_done(cpu_done),
    .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd),
    .bus_req_addr(bus_req_addr), .bus_gnt(bus_gnt),
    .bus_shared_in(bus_shared_in), .snp_valid(snp_valid),
    .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_shared(snp_shared), .snp_intervene(snp_intervene)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int tests, fails, cycles;
  bit done_flag;

  // behavioural model: 0 Invalid, 1 Shared, 2 Exclusive, 3 Modified
  int m_st [8];
  int m_tag [8];
  int r_sh, r_int;
  int o_req, o_cmd, o_addr, o_done, o_sh, o_int;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  // one clock: drive at negedge, compare, advance model past posedge
  task automatic cyc(input bit cv, input bit cw, input int ca, input bit sv,
                     input int sc, input int sa, input bit g, input bit sh);
    int e_req, e_cmd, e_addr, e_done, n_sh, n_int;
    bit wr;
    int wi, wt, ws, ci, ct, si, st;
    bit hit;
    cpu_req_valid = cv; cpu_req_write = cw; cpu_req_addr = ca[7:0];
    snp_valid = sv; snp_cmd = sc[1:0]; snp_addr = sa[7:0];
    bus_gnt = g; bus_shared_in = sh;
    #1;
    e_req = 0; e_cmd = 0; e_addr = 0; e_done = 0; n_sh = 0; n_int = 0;
    wr = 0; wi = 0; wt = 0; ws = 0;
    si = sa % 8; st = sa / 8; ci = ca % 8; ct = ca / 8;
    if (sv) begin
      if (m_st[si] != 0 && m_tag[si] == st) begin
        if (sc == 0) begin
          n_sh = 1; n_int = (m_st[si] == 3);
          wr = 1; wi = si; wt = st; ws = 1;
        end else if (sc != 3) begin
          n_int = (m_st[si] == 3);
          wr = 1; wi = si; wt = st; ws = 0;
        end
      end
    end else if (cv) begin
      hit = (m_st[ci] != 0 && m_tag[ci] == ct);
      if (!hit && m_st[ci] == 3) begin
        e_req = 1; e_cmd = 3; e_addr = m_tag[ci] * 8 + ci;
        if (g) begin wr = 1; wi = ci; wt = m_tag[ci]; ws = 0; end
      end else if (!cw) begin
        if (hit) e_done = 1;
        else begin
          e_req = 1; e_cmd = 0; e_addr = ca;
          if (g) begin e_done = 1; wr = 1; wi = ci; wt = ct; ws = sh ? 1 : 2; end
        end
      end else begin
        if (hit && m_st[ci] >= 2) begin
          e_done = 1; wr = 1; wi = ci; wt = ct; ws = 3;
        end else begin
          e_req = 1; e_cmd = hit ? 2 : 1; e_addr = ca;
          if (g) begin e_done = 1; wr = 1; wi = ci; wt = ct; ws = 3; end
        end
      end
    end
    o_req = int'(bus_req_valid); o_cmd = int'(bus_req_cmd); o_addr = int'(bus_req_addr);
    o_done = int'(cpu_done); o_sh = int'(snp_shared); o_int = int'(snp_intervene);
    chk(o_req == e_req, "model bus_req_valid (R1 R8 R9)", o_req, e_req);
    if (e_req != 0) begin
      chk(o_cmd == e_cmd, "model bus_req_cmd (R2 R3 R5 R10)", o_cmd, e_cmd);
      chk(o_addr == e_addr, "model bus_req_addr (R2 R10)", o_addr, e_addr);
    end
    chk(o_done == e_done, "model cpu_done (R4 R8 R9)", o_done, e_done);
    chk(o_sh == r_sh, "model snp_shared (R6 R11)", o_sh, r_sh);
    chk(o_int == r_int, "model snp_intervene (R6 R7)", o_int, r_int);
    @(posedge clk);
    r_sh = n_sh; r_int = n_int;
    if (wr) begin m_st[wi] = ws; m_tag[wi] = wt; end
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    int lfsr;
    tests = 0; fails = 0; cycles = 0; done_flag = 0;
    r_sh = 0; r_int = 0;
    for (int i = 0; i < 8; i++) begin m_st[i] = 0; m_tag[i] = 0; end
    rst_n = 1'b0;
    cpu_req_valid = 0; cpu_req_write = 0; cpu_req_addr = 0;
    snp_valid = 0; snp_cmd = 0; snp_addr = 0; bus_gnt = 0; bus_shared_in = 0;
    repeat (3) @(negedge clk);
    chk(snp_shared == 0 && snp_intervene == 0, "R1 reset responses idle", int'(snp_shared), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R2: first read misses, fills Exclusive
    cyc(1, 0, 8'h10, 0, 0, 0, 0, 0);
    chk(o_req == 1 && o_cmd == 0 && o_addr == 8'h10, "R1 first read requests fill", o_cmd, 0);
    cyc(1, 0, 8'h10, 0, 0, 0, 1, 0);
    chk(o_done == 1, "R2 fill completes on grant", o_done, 1);
    // R4: write to Exclusive is silent
    cyc(1, 1, 8'h10, 0, 0, 0, 0, 0);
    chk(o_done == 1 && o_req == 0, "R4 silent write on Exclusive", o_req, 0);
    // R8: write hit Modified
    cyc(1, 1, 8'h10, 0, 0, 0, 0, 0);
    chk(o_done == 1 && o_req == 0, "R8 write hit Modified", o_req, 0);
    // R6: snooped read of Modified line intervenes
    cyc(0, 0, 0, 1, 0, 8'h10, 0, 0);
    idle();
    chk(o_int == 1 && o_sh == 1, "R6 intervene on Modified read snoop", o_int, 1);
    // R5: line now Shared, write claims ownership
    cyc(1, 1, 8'h10, 0, 0, 0, 0, 0);
    chk(o_req == 1 && o_cmd == 2, "R5 write on Shared claims", o_cmd, 2);
    cyc(1, 1, 8'h10, 0, 0, 0, 1, 0);
    chk(o_done == 1, "R5 claim completes on grant", o_done, 1);

    // R2: shared fill then R8 read hit
    cyc(1, 0, 8'h21, 0, 0, 0, 1, 1);
    chk(o_done == 1, "R2 shared fill completes", o_done, 1);
    cyc(1, 0, 8'h21, 0, 0, 0, 0, 0);
    chk(o_done == 1 && o_req == 0, "R8 read hit Shared", o_req, 0);
    cyc(1, 1, 8'h21, 0, 0, 0, 0, 0);
    chk(o_cmd == 2, "R2 shared fill landed Shared", o_cmd, 2);
    // R7: snooped write intent on Shared line invalidates, no intervene
    cyc(0, 0, 0, 1, 1, 8'h21, 0, 0);
    idle();
    chk(o_int == 0 && o_sh == 0, "R7 claim snoop on Shared", o_int, 0);
    cyc(1, 0, 8'h21, 0, 0, 0, 0, 0);
    chk(o_req == 1 && o_cmd == 0, "R7 line invalidated", o_req, 1);

    // R3: write miss requests read-for-ownership
    cyc(1, 1, 8'h03, 0, 0, 0, 0, 0);
    chk(o_req == 1 && o_cmd == 1, "R3 write miss RFO", o_cmd, 1);
    cyc(1, 1, 8'h03, 0, 0, 0, 1, 0);
    // R10: conflicting miss writes back dirty victim first
    cyc(1, 0, 8'h0B, 0, 0, 0, 1, 0);
    chk(o_cmd == 3 && o_addr == 8'h03 && o_done == 0, "R10 victim writeback", o_addr, 8'h03);
    cyc(1, 0, 8'h0B, 0, 0, 0, 0, 0);
    chk(o_cmd == 0 && o_addr == 8'h0B, "R10 fill follows writeback", o_cmd, 0);
    cyc(1, 0, 8'h0B, 0, 0, 0, 1, 0);

    // R9: snoop blocks pending access, which retries
    cyc(1, 1, 8'h0B, 1, 1, 8'h0B, 1, 0);
    chk(o_req == 0 && o_done == 0, "R9 snoop blocks processor", o_done, 0);
    cyc(1, 1, 8'h0B, 0, 0, 0, 0, 0);
    chk(o_req == 1 && o_cmd == 1, "R9 retry sees invalidated line", o_cmd, 1);
    cyc(1, 1, 8'h0B, 0, 0, 0, 1, 0);
    // R7: claim snoop on Modified intervenes
    cyc(0, 0, 0, 1, 2, 8'h0B, 0, 0);
    idle();
    chk(o_int == 1 && o_sh == 0, "R7 intervene on Modified claim", o_int, 1);

    // R11: snoop miss and snooped writeback have no effect
    cyc(1, 0, 8'h44, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 1, 3, 8'h44, 0, 0);
    idle();
    chk(o_sh == 0 && o_int == 0, "R11 snooped writeback no response", o_sh, 0);
    cyc(1, 1, 8'h44, 0, 0, 0, 0, 0);
    chk(o_done == 1 && o_req == 0, "R11 line kept Exclusive", o_req, 0);
    cyc(0, 0, 0, 1, 0, 8'h55, 0, 0);
    idle();
    chk(o_sh == 0, "R11 snoop miss no response", o_sh, 0);

    // random phase, model compared every cycle
    lfsr = 32'h1ACE5;
    for (int n = 0; n < 4000; n++) begin
      lfsr = (lfsr << 1) ^ (((lfsr >> 31) & 1) != 0 ? 32'h04C11DB7 : 0);
      cyc(lfsr[0], lfsr[1], (lfsr >> 4) & 8'h1F, lfsr[12] & lfsr[13],
          (lfsr >> 14) & 3, (lfsr >> 16) & 8'h1F, lfsr[21], lfsr[22]);
    end
    finish_run();
  end
endmodule